// File: doc/BRIEF.md
# SPI Status and Fault Flag Controller

This block keeps the status and error bookkeeping of a single-buffered SPI port, in which one shift register serves as both the write buffer and the shifter. It decides whether a data-register write may load the shift engine. A write that arrives while a transfer is running is suppressed and recorded as a collision. It tracks completed transfers and receive overruns. It also watches the slave-select pin for a second master on the bus, and on such a fault it forces the port back to slave mode and turns the port off.

All four flags are sticky. Hardware sets them, and software clears one by writing 0 to its bit. One shared interrupt enable gates their OR onto a single registered interrupt request line. The mode-fault flag needs its own detection enable as well before it can raise the request. The serial shifting, clock generation and bus-side address decoding belong to the surrounding port logic.

Top module: `spi_flag_ctrl`

## Requirements
- R1: `load_o` is high in exactly the cycles where `dwr_i` is high and `busy_i` is low. A data write made while busy never reaches the shift engine.
- R2: A data write while `busy_i` is high sets the collision flag (`flags_o[2]`) at the next clock edge. The transfer in progress still completes, and its done pulse sets the transfer-complete flag.
- R3: The flags are sticky. Bit 0 is transfer complete, bit 1 is receive overrun, bit 2 is write collision and bit 3 is mode fault. A status write (`sts_we_i`) with a 0 in a bit position clears that flag at the next edge. A 1 in that position leaves the flag unchanged.
- R4: If a hardware set event and a software clear of the same flag fall in the same cycle, the flag ends up 1.
- R5: While the detection enable is 0, a low slave-select in master mode has no effect: the master-mode bit, the enable bit and the fault flag keep their values.
- R6: The slave-select pin passes through a two-flop synchronizer. Suppose the pin is low before edge k while the port is in master mode with detection enabled. Then at edge k+2, `master_o` and `en_o` become 0 and `flags_o[3]` becomes 1.
- R7: After a fault, the port stays in slave mode and disabled until software writes the control bits again. In the same cycle, a fault takes priority over a control write.
- R8: `irq_o` is a registered level. It rises one edge after an enabled flag sets, and it falls one edge after the last enabled flag is cleared.
- R9: Clearing the interrupt enable drops `irq_o` and leaves every flag unchanged. Setting the enable again while a flag is still 1 brings the request back.
- R10: The mode-fault flag contributes to `irq_o` only when both the interrupt enable and the detection enable are 1.
- R11: Reset (synchronous, active high) clears all flags, all control bits and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Shift engine has a transfer in progress |
| done_i | input | 1 | Transfer-complete pulse from the shift engine |
| ovr_i | input | 1 | Receive-overrun pulse |
| dwr_i | input | 1 | Data-register write strobe |
| ss_n_i | input | 1 | Slave-select pin, active low, asynchronous |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wd_i | input | 4 | Control write data {detect_en, irq_en, port_en, master} |
| sts_we_i | input | 1 | Status register write strobe |
| sts_wd_i | input | 4 | Status write data; a 0 clears the flag in that position |
| load_o | output | 1 | Qualified write that may load the shift register |
| flags_o | output | 4 | Sticky flags {fault, collision, overrun, complete} |
| master_o | output | 1 | Master-mode bit |
| en_o | output | 1 | Port-enable bit |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with a synchronizer depth of two stages, which puts the fault latency of R6 at a fixed, countable number of edges. A stub shift engine holds busy for eight cycles after each accepted load. That window is long enough to place colliding writes early, mid and late in a transfer, and to line a done pulse up with a status clear. A behavioural model, with the slave-select history kept in a queue, is compared against every output on every cycle. Directed scenarios cover same-cycle set/clear, a fault coinciding with a control write, and toggling of both enables with a flag held.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

    localparam int NFLAG   = 4;
    localparam int FLG_CMP = 0;
    localparam int FLG_OVR = 1;
    localparam int FLG_COL = 2;
    localparam int FLG_FLT = 3;

    typedef struct packed {
        logic fdet_en;
        logic irq_en;
        logic port_en;
        logic master;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic irq_source(input logic [NFLAG-1:0] f, input logic fdet);
        return f[FLG_CMP] | f[FLG_OVR] | f[FLG_COL] | (f[FLG_FLT] & fdet);
    endfunction

endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], pin_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs
    import spi_flag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we_i,
    input  ctl_t wd_i,
    input  logic fault_i,
    output ctl_t q_o
);
    ctl_t nxt;

    always_comb begin
        nxt = q_o;
        if (we_i) nxt = wd_i;
        if (fault_i) begin
            nxt.master  = 1'b0;
            nxt.port_en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= nxt;
    end
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
    import spi_flag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy_i,
    input  logic             done_i,
    input  logic             ovr_i,
    input  logic             dwr_i,
    input  logic             ss_n_i,
    input  logic             ctl_we_i,
    input  logic [CTL_W-1:0] ctl_wd_i,
    input  logic             sts_we_i,
    input  logic [NFLAG-1:0] sts_wd_i,
    output logic             load_o,
    output logic [NFLAG-1:0] flags_o,
    output logic             master_o,
    output logic             en_o,
    output logic             irq_o
);
    logic             ss_s;
    logic             fault;
    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;
    ctl_t             ctl_q;
    logic             irq_q;

    ss_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_i(ss_n_i), .sync_o(ss_s)
    );

    assign fault = ctl_q.fdet_en & ctl_q.master & ~ss_s;

    spi_ctl_regs u_ctl (
        .clk(clk), .rst(rst), .we_i(ctl_we_i), .wd_i(ctl_t'(ctl_wd_i)),
        .fault_i(fault), .q_o(ctl_q)
    );

    always_comb begin
        set_v          = '0;
        set_v[FLG_CMP] = done_i;
        set_v[FLG_OVR] = ovr_i;
        set_v[FLG_COL] = dwr_i & busy_i;
        set_v[FLG_FLT] = fault;
        clr_v          = sts_we_i ? ~sts_wd_i : '0;
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        sticky_flag u_flag (
            .clk(clk), .rst(rst), .set_i(set_v[g]), .clr_i(clr_v[g]), .q_o(flags_o[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= ctl_q.irq_en & irq_source(flags_o, ctl_q.fdet_en);
    end

    assign load_o   = dwr_i & ~busy_i;
    assign master_o = ctl_q.master;
    assign en_o     = ctl_q.port_en;
    assign irq_o    = irq_q;

    AST_COLLISION_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (dwr_i && busy_i) |=> flags_o[FLG_COL]); // R2

    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
        (flags_o[FLG_OVR] && !(sts_we_i && !sts_wd_i[FLG_OVR])) |=> flags_o[FLG_OVR]); // R3

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (done_i && sts_we_i && !sts_wd_i[FLG_CMP]) |=> flags_o[FLG_CMP]); // R4

    AST_NO_DETECT_OFF: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.fdet_en && master_o && !ctl_we_i) |=> master_o); // R5

    AST_FAULT_ACTION: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.fdet_en && master_o && !ss_s) |=> (!master_o && !en_o && flags_o[FLG_FLT])); // R6

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.irq_en |=> !irq_o); // R9

    AST_FAULT_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.fdet_en && flags_o[2:0] == 3'b000) |=> !irq_o); // R10
endmodule

// File: tb/sim_spi_flag_ctrl.sv
module sim_spi_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       busy_i, done_i, ovr_i, dwr_i, ss_n_i;
    logic       ctl_we_i, sts_we_i;
    logic [3:0] ctl_wd_i, sts_wd_i;
    logic       load_o, master_o, en_o, irq_o;
    logic [3:0] flags_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // reference model state
    int   xfer_left;
    bit   m_ss_q[$];
    bit   m_master, m_en, m_ie, m_fde, m_irq;
    bit   [3:0] m_flags;

    always #5 clk = ~clk;

    spi_flag_ctrl #(.SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .busy_i(busy_i), .done_i(done_i), .ovr_i(ovr_i),
        .dwr_i(dwr_i), .ss_n_i(ss_n_i), .ctl_we_i(ctl_we_i), .ctl_wd_i(ctl_wd_i),
        .sts_we_i(sts_we_i), .sts_wd_i(sts_wd_i), .load_o(load_o), .flags_o(flags_o),
        .master_o(master_o), .en_o(en_o), .irq_o(irq_o)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R3 flags", flags_o, m_flags);
        check("R6 master", master_o, m_master);
        check("R7 enable", en_o, m_en);
        check("R8 irq", irq_o, m_irq);
    endtask

    task automatic model_reset();
        m_ss_q = {1'b1, 1'b1};
        m_master = 0; m_en = 0; m_ie = 0; m_fde = 0; m_irq = 0; m_flags = 0;
        xfer_left = 0;
    endtask

    // one clock: drive at negedge, check combinational, step model at posedge, compare at negedge
    task automatic cycle(bit dwr, bit ovr, bit cwe, bit [3:0] cwd, bit swe, bit [3:0] swd);
        bit fault, busy, done, ld;
        bit [3:0] setv, clrv;
        busy = (xfer_left > 0);
        done = (xfer_left == 1);
        busy_i = busy; done_i = done; dwr_i = dwr; ovr_i = ovr;
        ctl_we_i = cwe; ctl_wd_i = cwd; sts_we_i = swe; sts_wd_i = swd;
        #1;
        ld = dwr && !busy;
        check("R1 load", load_o, ld);
        @(posedge clk);
        fault = m_fde && m_master && (m_ss_q[0] == 1'b0);
        m_irq = m_ie && (m_flags[0] || m_flags[1] || m_flags[2] || (m_flags[3] && m_fde));
        setv = {fault, dwr && busy, ovr, done};
        clrv = swe ? ~swd : 4'b0000;
        m_flags = setv | (m_flags & ~clrv);
        if (cwe) begin
            m_fde = cwd[3]; m_ie = cwd[2]; m_en = cwd[1]; m_master = cwd[0];
        end
        if (fault) begin m_master = 0; m_en = 0; end
        void'(m_ss_q.pop_front());
        m_ss_q.push_back(ss_n_i);
        if (ld) xfer_left = 8;
        else if (xfer_left > 0) xfer_left--;
        @(negedge clk);
        cyc++;
        compare_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 4'h0, 0, 4'h0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        busy_i = 0; done_i = 0; dwr_i = 0; ovr_i = 0; ss_n_i = 1;
        ctl_we_i = 0; ctl_wd_i = 0; sts_we_i = 0; sts_wd_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R11 reset flags", flags_o, 0);
        check("R11 reset master", master_o, 0);
        check("R11 reset enable", en_o, 0);
        check("R11 reset irq", irq_o, 0);
    endtask

    initial begin
        do_reset();

        // R1 R2: start transfer, collide mid-transfer, done still arrives
        cycle(0, 0, 1, 4'b0111, 0, 0);            // ie=1 en=1 master=1 fde=0
        cycle(1, 0, 0, 0, 0, 0);                  // accepted load
        idle(2);
        cycle(1, 0, 0, 0, 0, 0);                  // collision
        check("R2 collision flag", flags_o[2], 1);
        idle(1);
        check("R8 irq after collision", irq_o, 1);
        idle(6);
        check("R2 transfer still completes", flags_o[0], 1);

        // R3: write 1 no effect, write 0 clears
        cycle(0, 0, 0, 0, 1, 4'b1111);
        check("R3 write one keeps", flags_o, 4'b0101);
        cycle(0, 0, 0, 0, 1, 4'b1011);
        check("R3 write zero clears", flags_o, 4'b0001);
        cycle(0, 0, 0, 0, 1, 4'b1110);
        check("R3 clear last", flags_o, 4'b0000);
        idle(1);
        check("R8 irq falls after last clear", irq_o, 0);

        // R4: overrun set and clear same cycle
        cycle(0, 1, 0, 0, 1, 4'b1101);
        check("R4 set wins", flags_o[1], 1);
        // R9: disable irq, flags kept, re-enable
        cycle(0, 0, 1, 4'b0011, 0, 0);
        idle(1);
        check("R9 irq off", irq_o, 0);
        check("R9 flag kept", flags_o[1], 1);
        cycle(0, 0, 1, 4'b0111, 0, 0);
        idle(1);
        check("R9 irq back", irq_o, 1);
        cycle(0, 0, 0, 0, 1, 4'b0000);
        idle(2);

        // R5: detection off, ss low in master mode
        ss_n_i = 0;
        idle(5);
        check("R5 master kept", master_o, 1);
        check("R5 no fault", flags_o[3], 0);
        ss_n_i = 1;
        idle(3);

        // R6: detection on, latency count
        cycle(0, 0, 1, 4'b1111, 0, 0);
        idle(2);
        ss_n_i = 0;
        cycle(0, 0, 0, 0, 0, 0);                  // edge k
        check("R6 not yet k", master_o, 1);
        cycle(0, 0, 0, 0, 0, 0);                  // edge k+1
        check("R6 not yet k1", master_o, 1);
        cycle(0, 0, 0, 0, 0, 0);                  // edge k+2
        check("R6 master cleared", master_o, 0);
        check("R6 enable cleared", en_o, 0);
        check("R6 fault flag", flags_o[3], 1);
        ss_n_i = 1;
        idle(4);
        check("R7 stays slave", master_o, 0);
        check("R10 fault irq with fde", irq_o, 1);

        // R10: fde off hides fault from irq
        cycle(0, 0, 1, 4'b0100, 0, 0);
        idle(1);
        check("R10 fault masked", irq_o, 0);
        check("R10 flag kept", flags_o[3], 1);
        cycle(0, 0, 0, 0, 1, 4'b0111);
        idle(1);

        // R7: fault beats simultaneous control write
        cycle(0, 0, 1, 4'b1111, 0, 0);
        ss_n_i = 0;
        idle(2);
        cycle(0, 0, 1, 4'b1111, 0, 0);
        check("R7 fault priority master", master_o, 0);
        check("R7 fault priority enable", en_o, 0);
        ss_n_i = 1;
        idle(3);
        cycle(0, 0, 1, 4'b0111, 0, 0);
        check("R7 software restores master", master_o, 1);

        // R1 R2: collide on first and last busy cycle
        cycle(0, 0, 0, 0, 1, 4'b0000);
        cycle(1, 0, 0, 0, 0, 0);
        cycle(1, 0, 0, 0, 0, 0);
        idle(6);
        cycle(1, 0, 0, 0, 0, 0);
        check("R2 late collision", flags_o[2], 1);
        idle(3);

        // reset mid-activity
        cycle(0, 1, 0, 0, 0, 0);
        do_reset();
        idle(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n = 0;
        while (n < 100000) begin
            @(posedge clk);
            n++;
        end
        errors++;
        $display("FAIL watchdog expired actual %0d expected less", n);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule